// File: doc/BRIEF.md
# Coherent Calendar Register Bank

This block keeps seven BCD timekeeping bytes (seconds, minutes, hours with century control, day of week, day of month, month and year) between a byte-wide register port and a set of running calendar counters. Software sees a staging copy of the time and never the counters themselves. Bytes written at the timekeeping addresses collect in the staging copy. They reach the counters together, in one clock, when the access is closed by a bus STOP or by a write to one of the control addresses. Counters whose byte was not written keep running.

A read of a timekeeping address freezes the staging copy, so a multi-byte read cannot see a rollover part way through. When the staging copy is neither frozen, halted nor holding staged bytes, it follows the counters one clock behind. A halt flag, set on entry to backup supply or by software, stops that tracking so the power-down time stays readable while the counters run on. A sub-second tick input feeds a divider of `TICKS_PER_SEC` ticks per second. Committing a time write clears this divider, and setting the seconds stop bit makes the divider ignore ticks.

Top module: `cal_xfer_bank`

## Requirements
- R1: After reset, reads of addresses 0..6 return 00h, 00h, 00h, 01h, 01h, 01h, 00h. Address 9 reads 00h.
- R2: A write to address 0..6 changes only the staging byte. While any staged byte is pending, the staging copy does not follow the counters.
- R3: A bus STOP, or a write to address 7, 8 or 9, while bytes are staged copies every staged byte into its counter at the same clock edge. Counters with no staged byte keep their running value.
- R4: A commit clears the sub-second divider. The seconds count then advances on the `TICKS_PER_SEC`-th accepted tick after the commit.
- R5: When the staging copy is not frozen, not halted and holds no staged byte, it takes the counter values one clock after they change.
- R6: A read strobe at address 0..6 freezes the staging copy. A bus STOP, or a read strobe at address 7..9, releases it.
- R7: A rising edge on `backup_mode` sets the halt flag (address 9 bit 7). While the flag is set, the staging copy holds its values but the counters keep running. A write to address 9 loads bit 7 of the data into the flag, and a backup edge wins over a write in the same clock.
- R8: While seconds bit 7 (the stop bit) is 1, sub-second ticks are ignored and the counters hold their values.
- R9: Seconds wrap 59 to 00 and minutes wrap 59 to 00, each carrying into the next field. Hours (bits 5:0) wrap 23 to 00 and advance both the date and the day of week (bits 2:0), which wraps 7 to 1.
- R10: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 28 for month 02, or 29 when the BCD year is a multiple of 4, and 31 for the other months. The month wraps 12 to 01 and carries into the year.
- R11: When the year wraps 99 to 00, hours bit 6 (century) toggles only if hours bit 7 (century enable) is 1.
- R12: The following bits are stored as 0 whatever is written to them: minutes bit 7, day bits 7 and 3, date bits 7:6, month bits 7:5.
- R13: Addresses 7, 8 and 10..15 read 00h, and bits 6:0 of address 9 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Sub-second tick, one clock wide |
| backup_mode | input | 1 | High while running from backup supply |
| reg_addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, used for freeze control |
| wr_data | input | 8 | Write data |
| bus_stop | input | 1 | One-clock pulse when the bus sees STOP |
| rd_data | output | 8 | Read data for `reg_addr`, combinational |

## Verification
The counters can only be seen through the staging copy. If a counter goes wrong, the error shows up at `rd_data` one clock after the next refresh. It can stay hidden for as long as the copy is frozen, halted or holding staged bytes. Errors in the divider or in a commit show up as a second that arrives one or more ticks early or late. Errors in the freeze, halt or staged-byte flags show up at once as a byte that follows the counters when it should hold, or holds when it should follow. For this reason the reference model compares the read port on every clock, not only at the directed checks.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NREG     = 7;
    localparam int ADDR_W   = 4;
    localparam int IX_SEC   = 0;
    localparam int IX_MIN   = 1;
    localparam int IX_HR    = 2;
    localparam int IX_DAY   = 3;
    localparam int IX_DATE  = 4;
    localparam int IX_MON   = 5;
    localparam int IX_YEAR  = 6;
    localparam logic [ADDR_W-1:0] CTRL_LO   = 4'd7;
    localparam logic [ADDR_W-1:0] CTRL_HI   = 4'd9;
    localparam logic [ADDR_W-1:0] HALT_ADDR = 4'd9;

    typedef logic [NREG-1:0][7:0] bank_t;

    typedef struct packed {
        logic       carry;
        logic [7:0] val;
    } bcd_step_t;

    // year, month, date, day, hours, minutes, seconds
    localparam bank_t RESET_BANK = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic bcd_step_t bcd_step(input logic [7:0] v,
                                           input logic [7:0] top,
                                           input logic [7:0] base);
        bcd_step_t r;
        if (v >= top) begin
            r.carry = 1'b1;
            r.val   = base;
        end else if (v[3:0] >= 4'd9) begin
            r.carry = 1'b0;
            r.val   = {v[7:4] + 4'd1, 4'h0};
        end else begin
            r.carry = 1'b0;
            r.val   = v + 8'd1;
        end
        return r;
    endfunction

    // BCD year multiple of four: even tens with 0/4/8 units, odd tens with 2/6
    function automatic logic bcd_leap(input logic [7:0] yr);
        logic [3:0] u;
        u = yr[3:0];
        if (yr[4]) return (u == 4'd2) || (u == 4'd6);
        return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    endfunction

    function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] write_mask(input int idx);
        case (idx)
            IX_MIN:  return 8'h7F;
            IX_DAY:  return 8'h77;
            IX_DATE: return 8'h3F;
            IX_MON:  return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/cal_divider.sv
module cal_divider
#(
    parameter int TICKS_PER_SEC = 4
)
(
    input  logic clk,
    input  logic rst,
    input  logic sub_tick,
    input  logic osc_stop,
    input  logic clear,
    output logic sec_pulse,
    output logic phase_zero
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0] phase_q;
    logic          take;

    assign take       = sub_tick && !osc_stop;
    assign sec_pulse  = take && (phase_q == LAST) && !clear;
    assign phase_zero = (phase_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (take) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
        end
    end
endmodule

// File: rtl/cal_counters.sv
module cal_counters
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_pulse,
    input  logic              load,
    input  logic [NREG-1:0]   load_sel,
    input  bank_t             load_val,
    output bank_t             cnt
);
    bank_t     cnt_q;
    bank_t     nxt;
    bcd_step_t s_st, m_st, h_st, w_st, d_st, mo_st, y_st;

    always_comb begin
        s_st  = bcd_step({1'b0, cnt_q[IX_SEC][6:0]}, 8'h59, 8'h00);
        m_st  = bcd_step({1'b0, cnt_q[IX_MIN][6:0]}, 8'h59, 8'h00);
        h_st  = bcd_step({2'b0, cnt_q[IX_HR][5:0]},  8'h23, 8'h00);
        w_st  = bcd_step({5'b0, cnt_q[IX_DAY][2:0]}, 8'h07, 8'h01);
        d_st  = bcd_step({2'b0, cnt_q[IX_DATE][5:0]},
                         month_end(cnt_q[IX_MON], cnt_q[IX_YEAR]), 8'h01);
        mo_st = bcd_step({3'b0, cnt_q[IX_MON][4:0]}, 8'h12, 8'h01);
        y_st  = bcd_step(cnt_q[IX_YEAR], 8'h99, 8'h00);

        nxt = cnt_q;
        nxt[IX_SEC] = {cnt_q[IX_SEC][7], s_st.val[6:0]};
        if (s_st.carry) begin
            nxt[IX_MIN] = {1'b0, m_st.val[6:0]};
            if (m_st.carry) begin
                nxt[IX_HR] = {cnt_q[IX_HR][7:6], h_st.val[5:0]};
                if (h_st.carry) begin
                    nxt[IX_DAY]  = {1'b0, cnt_q[IX_DAY][6:4], 1'b0, w_st.val[2:0]};
                    nxt[IX_DATE] = {2'b0, d_st.val[5:0]};
                    if (d_st.carry) begin
                        nxt[IX_MON] = {3'b0, mo_st.val[4:0]};
                        if (mo_st.carry) begin
                            nxt[IX_YEAR] = y_st.val;
                            if (y_st.carry && cnt_q[IX_HR][7]) begin
                                nxt[IX_HR][6] = ~cnt_q[IX_HR][6];
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RESET_BANK;
        end else if (load) begin
            for (int i = 0; i < NREG; i++) begin
                if (load_sel[i]) cnt_q[i] <= load_val[i];
            end
        end else if (sec_pulse) begin
            cnt_q <= nxt;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cal_stage.sv
module cal_stage
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wr_data,
    input  logic              bus_stop,
    input  logic              backup_rise,
    input  bank_t             cnt,
    output bank_t             stage,
    output logic              halt,
    output logic              frozen,
    output logic              commit,
    output logic [NREG-1:0]   commit_sel
);
    bank_t           stage_q;
    bank_t           wmask;
    logic [NREG-1:0] dirty_q;
    logic            frozen_q, halt_q;
    logic            tk_addr, ctl_addr, wr_tk, refresh;

    for (genvar g = 0; g < NREG; g++) begin : g_mask
        assign wmask[g] = write_mask(g);
    end

    assign tk_addr    = addr < ADDR_W'(NREG);
    assign ctl_addr   = (addr >= CTRL_LO) && (addr <= CTRL_HI);
    assign wr_tk      = wr_en && tk_addr;
    assign commit     = (bus_stop || (wr_en && ctl_addr)) && (|dirty_q);
    assign commit_sel = dirty_q;
    assign refresh    = !frozen_q && !halt_q && (dirty_q == '0) && !wr_tk;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= RESET_BANK;
            dirty_q  <= '0;
            frozen_q <= 1'b0;
            halt_q   <= 1'b0;
        end else begin
            if (refresh) stage_q <= cnt;
            if (commit) dirty_q <= '0;
            for (int i = 0; i < NREG; i++) begin
                if (wr_tk && (addr == ADDR_W'(i))) begin
                    stage_q[i] <= wr_data & wmask[i];
                    dirty_q[i] <= 1'b1;
                end
            end
            if (bus_stop || (rd_en && ctl_addr)) frozen_q <= 1'b0;
            else if (rd_en && tk_addr)           frozen_q <= 1'b1;
            if (backup_rise)                      halt_q <= 1'b1;
            else if (wr_en && addr == HALT_ADDR) halt_q <= wr_data[7];
        end
    end

    assign stage  = stage_q;
    assign halt   = halt_q;
    assign frozen = frozen_q;
endmodule

// File: rtl/cal_xfer_bank.sv
module cal_xfer_bank
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4
)
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sub_tick,
    input  logic        backup_mode,
    input  logic [3:0]  reg_addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wr_data,
    input  logic        bus_stop,
    output logic [7:0]  rd_data
);
    bank_t           cnt_bank, stage_bank;
    logic            halt, frozen, commit, sec_pulse, phase_zero, bk_q;
    logic [NREG-1:0] commit_sel;

    always_ff @(posedge clk) begin
        if (rst) bk_q <= 1'b0;
        else     bk_q <= backup_mode;
    end

    cal_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk(clk), .rst(rst), .sub_tick(sub_tick),
        .osc_stop(cnt_bank[IX_SEC][7]), .clear(commit),
        .sec_pulse(sec_pulse), .phase_zero(phase_zero)
    );

    cal_counters u_cnt (
        .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .load(commit),
        .load_sel(commit_sel), .load_val(stage_bank), .cnt(cnt_bank)
    );

    cal_stage u_stage (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .bus_stop(bus_stop), .backup_rise(backup_mode && !bk_q),
        .cnt(cnt_bank), .stage(stage_bank), .halt(halt), .frozen(frozen),
        .commit(commit), .commit_sel(commit_sel)
    );

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (reg_addr == 4'(i)) rd_data = stage_bank[i];
        end
        if (reg_addr == HALT_ADDR) rd_data = {halt, 7'b0};
    end
endmodule

// File: rtl/cal_xfer_bank_chk.sv
module cal_xfer_bank_chk
    import cal_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        sub_tick,
    input logic        backup_mode,
    input logic        wr_en,
    input logic [3:0]  reg_addr,
    input logic [7:0]  rd_data,
    input logic        halt,
    input logic        frozen,
    input logic        commit,
    input logic        phase_zero,
    input bank_t       cnt_bank,
    input bank_t       stage_bank
);
    assert_staged_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr < 4'd7 && !sub_tick && !commit) |=> $stable(cnt_bank));

    assert_commit_clears_div_R4: assert property (@(posedge clk) disable iff (rst)
        commit |=> phase_zero);

    assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (frozen && !wr_en) |=> $stable(stage_bank));

    assert_backup_sets_halt_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(backup_mode) |=> halt);

    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (halt && !wr_en) |=> $stable(stage_bank));

    assert_stop_bit_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_bank[IX_SEC][7] && !commit) |=> $stable(cnt_bank));

    assert_min_msb_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 4'd1) |-> (rd_data[7] == 1'b0));

    assert_ctrl_reads_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 4'd7 || reg_addr == 4'd8 || reg_addr >= 4'd10) |-> (rd_data == 8'h00));
endmodule

bind cal_xfer_bank cal_xfer_bank_chk u_chk (
    .clk(clk), .rst(rst), .sub_tick(sub_tick), .backup_mode(backup_mode),
    .wr_en(wr_en), .reg_addr(reg_addr), .rd_data(rd_data), .halt(halt),
    .frozen(frozen), .commit(commit), .phase_zero(phase_zero),
    .cnt_bank(cnt_bank), .stage_bank(stage_bank)
);

// File: tb/cal_xfer_bank_test.sv
`timescale 1ns/1ps
module cal_xfer_bank_test;
    localparam int T  = 4;
    localparam real HALF = 2.0;

    logic clk = 0, rst = 1, sub_tick = 0, backup_mode = 0;
    logic [3:0] reg_addr = 0;
    logic wr_en = 0, rd_en = 0, bus_stop = 0;
    logic [7:0] wr_data = 0, rd_data;
    int ntests = 0, nfail = 0;
    bit done = 0;

    always #(HALF) clk = ~clk;

    cal_xfer_bank #(.TICKS_PER_SEC(T)) uut (
        .clk(clk), .rst(rst), .sub_tick(sub_tick), .backup_mode(backup_mode),
        .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .bus_stop(bus_stop), .rd_data(rd_data)
    );

    // ---------------- behavioural reference model ----------------
    int mc[7], mb[7];
    bit md[7];
    bit mfz, mht, mbk;
    int mph;

    function automatic int b2i(int v); return (v >> 4) * 10 + (v & 15); endfunction
    function automatic int i2b(int v); return ((v / 10) << 4) | (v % 10); endfunction
    function automatic int mask_of(int i);
        case (i) 1: return 'h7F; 3: return 'h77; 4: return 'h3F; 5: return 'h1F; default: return 'hFF; endcase
    endfunction
    function automatic int days_of(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        int init[7] = '{0, 0, 0, 1, 1, 1, 0};
        for (int i = 0; i < 7; i++) begin mc[i] = init[i]; mb[i] = init[i]; md[i] = 0; end
        mfz = 0; mht = 0; mbk = 0; mph = 0;
    endtask

    task automatic model_step();
        int nc[7];
        bit any = 0, tk, ctl, com, stp, pulse;
        int s, mi, h, dw, dt, mo, yr;
        for (int i = 0; i < 7; i++) begin nc[i] = mc[i]; any |= md[i]; end
        tk  = reg_addr < 7;
        ctl = reg_addr >= 7 && reg_addr <= 9;
        com = (bus_stop || (wr_en && ctl)) && any;
        stp = mc[0][7];
        pulse = sub_tick && !stp && mph == T - 1 && !com;
        if (com) begin
            for (int i = 0; i < 7; i++) if (md[i]) nc[i] = mb[i];
        end else if (pulse) begin
            s = b2i(mc[0] & 'h7F); mi = b2i(mc[1] & 'h7F); h = b2i(mc[2] & 'h3F);
            dw = mc[3] & 7; dt = b2i(mc[4] & 'h3F); mo = b2i(mc[5] & 'h1F); yr = b2i(mc[6]);
            s++;
            if (s == 60) begin
                s = 0; mi++;
                if (mi == 60) begin
                    mi = 0; h++;
                    if (h == 24) begin
                        h = 0; dw = (dw >= 7) ? 1 : dw + 1; dt++;
                        if (dt > days_of(mo, yr)) begin
                            dt = 1; mo++;
                            if (mo == 13) begin
                                mo = 1; yr++;
                                if (yr == 100) begin
                                    yr = 0;
                                    if (mc[2][7]) nc[2] = nc[2] ^ 'h40;
                                end
                            end
                        end
                    end
                end
            end
            nc[0] = (mc[0] & 'h80) | i2b(s);
            nc[1] = i2b(mi);
            nc[2] = (nc[2] & 'hC0) | i2b(h);
            nc[3] = (mc[3] & 'h70) | dw;
            nc[4] = i2b(dt); nc[5] = i2b(mo); nc[6] = i2b(yr);
        end
        if (com) mph = 0;
        else if (sub_tick && !stp) mph = (mph == T - 1) ? 0 : mph + 1;
        if (!mfz && !mht && !any && !(wr_en && tk))
            for (int i = 0; i < 7; i++) mb[i] = mc[i];
        if (com) for (int i = 0; i < 7; i++) md[i] = 0;
        if (wr_en && tk) begin mb[reg_addr] = wr_data & mask_of(reg_addr); md[reg_addr] = 1; end
        if (bus_stop || (rd_en && ctl)) mfz = 0;
        else if (rd_en && tk) mfz = 1;
        if (backup_mode && !mbk) mht = 1;
        else if (wr_en && reg_addr == 9) mht = wr_data[7];
        mbk = backup_mode;
        for (int i = 0; i < 7; i++) mc[i] = nc[i];
    endtask

    function automatic int model_read(int a);
        if (a < 7) return mb[a];
        if (a == 9) return mht ? 'h80 : 0;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) model_reset();
        else     model_step();
    end

    always @(negedge clk) begin
        #0.5;
        if (!rst && !done) begin
            ntests++;
            if (rd_data !== 8'(model_read(reg_addr))) begin
                nfail++;
                $display("FAIL R5 per-clock model addr %0d: actual %02h expected %02h",
                         reg_addr, rd_data, 8'(model_read(reg_addr)));
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); sub_tick = 1; end
        @(negedge clk); sub_tick = 0;
    endtask
    task automatic wr(int a, int d);
        @(negedge clk); reg_addr = 4'(a); wr_data = 8'(d); wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask
    task automatic rd(int a);
        @(negedge clk); reg_addr = 4'(a); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask
    task automatic stop();
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask
    task automatic peek(int a, int exp, string tag);
        reg_addr = 4'(a);
        #0.25;
        ntests++;
        if (rd_data !== 8'(exp)) begin
            nfail++;
            $display("FAIL %s addr %0d: actual %02h expected %02h", tag, a, rd_data, 8'(exp));
        end
    endtask
    task automatic set_time(int s, int mi, int h, int dw, int dt, int mo, int yr);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr); stop();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    endtask

    initial begin
        #(4.0 * 200000);
        ntests++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // R1 reset values
        peek(0, 'h00, "R1"); peek(1, 'h00, "R1"); peek(2, 'h00, "R1"); peek(3, 'h01, "R1");
        peek(4, 'h01, "R1"); peek(5, 'h01, "R1"); peek(6, 'h00, "R1"); peek(9, 'h00, "R1");

        // R3 full commit, R9/R11 rollover with century enable
        set_time('h58, 'h59, 'hA3, 'h07, 'h31, 'h12, 'h99);
        idle(2);
        peek(2, 'hA3, "R3"); peek(6, 'h99, "R3");
        tick(4);
        peek(0, 'h58, "R5 lag");
        idle(1);
        peek(0, 'h59, "R5");
        tick(4); idle(1);
        peek(0, 'h00, "R9"); peek(1, 'h00, "R9"); peek(3, 'h01, "R9 weekday");
        peek(4, 'h01, "R10"); peek(5, 'h01, "R10"); peek(6, 'h00, "R10");
        peek(2, 'hC0, "R11 century toggle");

        // R3 partial commit via control write
        wr(1, 'h15); wr(7, 'h00); idle(2);
        peek(1, 'h15, "R3"); peek(0, 'h00, "R3 unwritten"); peek(2, 'hC0, "R3 unwritten");

        // R4 divider cleared on commit
        tick(3); wr(0, 'h10); stop();
        tick(3); idle(1); peek(0, 'h10, "R4");
        tick(1); idle(1); peek(0, 'h11, "R4");

        // R2 staged write ignores ticks until commit
        wr(0, 'h45); tick(4); idle(1); peek(0, 'h45, "R2");
        stop(); idle(1); peek(0, 'h45, "R2 commit");

        // R8 stop bit
        wr(0, 'hA0); stop(); tick(8); idle(1); peek(0, 'hA0, "R8");
        wr(0, 'h20); stop(); tick(4); idle(1); peek(0, 'h21, "R8 resume");

        // R6 freeze and release
        rd(0); tick(4); idle(1); peek(0, 'h21, "R6 frozen");
        rd(8); idle(1); peek(0, 'h22, "R6 released");

        // R7 halt on backup
        @(negedge clk); backup_mode = 1;
        idle(2); peek(9, 'h80, "R7");
        tick(4); idle(1); peek(0, 'h22, "R7 halted");
        @(negedge clk); backup_mode = 0;
        wr(9, 'h00); idle(1); peek(0, 'h23, "R7 resumed"); peek(9, 'h00, "R7");
        wr(9, 'h80); peek(9, 'h80, "R7 sw set"); wr(9, 'h00); idle(1);

        // R10 leap and month lengths
        set_time('h59, 'h59, 'h23, 'h02, 'h28, 'h02, 'h24);
        tick(4); idle(1); peek(4, 'h29, "R10 leap"); peek(5, 'h02, "R10 leap");
        set_time('h59, 'h59, 'h23, 'h02, 'h28, 'h02, 'h23);
        tick(4); idle(1); peek(4, 'h01, "R10 non-leap"); peek(5, 'h03, "R10 non-leap");
        set_time('h59, 'h59, 'h23, 'h02, 'h30, 'h04, 'h23);
        tick(4); idle(1); peek(4, 'h01, "R10 30-day"); peek(5, 'h05, "R10 30-day");

        // R11 century bit held without enable
        set_time('h59, 'h59, 'h63, 'h05, 'h31, 'h12, 'h99);
        tick(4); idle(1); peek(2, 'h40, "R11 no enable"); peek(6, 'h00, "R11");

        // R12 masked bits
        wr(1, 'hFF); peek(1, 'h7F, "R12");
        wr(3, 'hFF); peek(3, 'h77, "R12");
        wr(4, 'hFF); peek(4, 'h3F, "R12");
        wr(5, 'hFF); peek(5, 'h1F, "R12");
        wr(1, 'h00); wr(3, 'h01); wr(4, 'h01); wr(5, 'h01); stop(); idle(2);

        // R13 unused addresses
        peek(7, 'h00, "R13"); peek(8, 'h00, "R13"); peek(10, 'h00, "R13");
        peek(15, 'h00, "R13"); peek(9, 'h00, "R13");

        idle(2);
        summary();
    end
endmodule